// File: doc/BRIEF.md
# Receive Word Framer with Training Search

This block sits behind a deserializer that delivers one W-bit word per clock with an unknown bit offset relative to the transmitter's word boundaries. It keeps the newest captured word and the one before it as a 2W-bit window. A funnel shifter cuts W contiguous bits out of that window at a selectable offset, so a fixed offset realigns every word of the stream.

After reset the block searches for the offset on its own. The transmitter sends a training stream that alternates between two fixed words. A matcher compares the current slice with both words. A small state machine steps the offset on every failed word, and it locks once enough correct alternating pairs have arrived in a row. A control path sees the raw captured word, the framed word and the offset in use. It can force an offset, which also suspends the search, and it can request a fresh search.

Top module: `rx_word_framer`

## Requirements
- R1: With offset o in use, the framed output after clock edge n+1 equals bits o to o+W-1 of the value {word captured at edge n, word captured at edge n-1}. The newer word holds the upper W bits.
- R2: The raw output shows the input word captured at the previous clock edge.
- R3: A slice counts as a training word only if, written bit W-1 down to bit 0, it equals 0101010100 (word A) or its complement 1010101011 (word B), for W=10.
- R4: After reset the offset is 0. While searching, each slice that fails moves the offset up by one, and offset W-1 wraps to 0.
- R5: Lock is declared once 2*LOCK_PAIRS consecutive slices (8 by default) match training words that alternate between A and B. The locked output rises at the edge that takes in the last of these slices. A training word equal to the word before it counts as a failure.
- R6: While locked, and with no override and no retrain request, the offset and the locked output hold whatever data arrives.
- R7: A retrain request clears lock. The search then restarts from the offset already in use, not from 0.
- R8: While override is on, the offset in use is the override value, with values above W-1 treated as W-1, and locked is low. After release the search starts from that value.
- R9: The offset monitor output shows the offset in use and never exceeds W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one word per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_word | input | W | Word from the deserializer |
| retrain | input | 1 | Request a new search (one cycle) |
| ovr_en | input | 1 | Force the offset from ovr_offset |
| ovr_offset | input | OW | Forced offset value |
| framed_word | output | W | Realigned output word |
| raw_word | output | W | Captured input word, before framing |
| off_mon | output | OW | Offset currently in use |
| locked | output | 1 | Search finished, offset frozen |

## Verification
The search is run on training streams delayed by 3, 5 and 8 bits. The resulting offset shows that the matcher accepts only the true word boundary, since shifted copies of the training words never match. Random data sent at several fixed offsets, including the clamped forced value, checks that the funnel slice picks the right bits from both halves of the window. A stream of only word A shows that matching words that do not alternate never lead to lock. A counted release after a forced offset pins down the exact word on which lock is declared. A retrain after a change of delay shows, from the number of words needed to relock, that the search resumes from the current offset.

// File: rtl/rwf_pkg.sv
// Shared types and helpers for the receive word framer.
// Assumes word widths of at most 32 bits.
package rwf_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } fr_state_e;

    // Training word A: bits 0 and 1 low, then alternating, starting high at bit 2.
    function automatic logic [31:0] train_a(input int w);
        logic [31:0] r;
        r = '0;
        for (int i = 2; i < w; i++) begin
            if ((i % 2) == 0) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rwf_window.sv
// Capture stage and funnel shifter.
// Keeps the newest and previous words and cuts a W-bit slice at offset off_sel.
// Assumes off_sel is already limited to 0..W-1.
module rwf_window #(
    parameter int W  = 10,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  rx_word,
    input  logic [OW-1:0] off_sel,
    output logic [W-1:0]  cur_word,
    output logic [W-1:0]  slice,
    output logic [W-1:0]  framed_word
);
    logic [W-1:0]   prev_word;
    logic [2*W-1:0] window;

    assign window = {cur_word, prev_word};

    // Shift the two-word history on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word  <= '0;
            prev_word <= '0;
        end else begin
            cur_word  <= rx_word;
            prev_word <= cur_word;
        end
    end

    // Funnel: select the slice starting at the chosen offset.
    always_comb begin
        slice = '0;
        for (int o = 0; o < W; o++) begin
            if (off_sel == OW'(o)) slice = window[o +: W];
        end
    end

    // Register the framed word.
    always_ff @(posedge clk) begin
        if (!rst_n) framed_word <= '0;
        else        framed_word <= slice;
    end
endmodule

// File: rtl/rwf_matcher.sv
// Training word matcher: flags when the slice equals word A or word B (~A).
// Purely combinational.
module rwf_matcher #(
    parameter int W = 10
) (
    input  logic [W-1:0] slice,
    output logic         is_a,
    output logic         is_b
);
    localparam logic [W-1:0] TRAIN_A = W'(rwf_pkg::train_a(W));
    localparam logic [W-1:0] TRAIN_B = ~TRAIN_A;

    // Compare the slice against both training words.
    always_comb begin
        is_a = (slice == TRAIN_A);
        is_b = (slice == TRAIN_B);
    end
endmodule

// File: rtl/rwf_train_fsm.sv
// Search and lock controller.
// Steps the offset on each failed slice and locks after LOCK_WORDS alternating
// matches. Override takes priority over retrain, and retrain over the search.
module rwf_train_fsm #(
    parameter int W         = 10,
    parameter int OW        = 4,
    parameter int LOCK_PAIRS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_a,
    input  logic          is_b,
    input  logic          retrain,
    input  logic          ovr_en,
    input  logic [OW-1:0] ovr_offset,
    output logic [OW-1:0] eff_off,
    output logic          locked
);
    import rwf_pkg::*;

    localparam int LOCK_WORDS = 2 * LOCK_PAIRS;
    localparam int CW         = $clog2(LOCK_WORDS + 1);
    localparam logic [OW-1:0] OFF_MAX = OW'(W - 1);

    fr_state_e     state;
    logic [OW-1:0] off_q;
    logic [CW-1:0] run_cnt;
    logic          last_a;
    logic [OW-1:0] ovr_clamped;
    logic          good;

    // Limit the forced offset to the legal range.
    assign ovr_clamped = (ovr_offset > OFF_MAX) ? OFF_MAX : ovr_offset;
    // Offset in use: forced value or the searched one.
    assign eff_off = ovr_en ? ovr_clamped : off_q;
    // A slice counts when it is a training word that differs from the last one.
    assign good = (is_a || is_b) && ((run_cnt == '0) || (is_a != last_a));
    assign locked = (state == ST_LOCK);

    // Search, lock and control handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            off_q   <= '0;
            run_cnt <= '0;
            last_a  <= 1'b0;
        end else if (ovr_en) begin
            state   <= ST_HUNT;
            off_q   <= ovr_clamped;
            run_cnt <= '0;
        end else if (retrain) begin
            state   <= ST_HUNT;
            run_cnt <= '0;
        end else if (state == ST_HUNT) begin
            if (good) begin
                last_a  <= is_a;
                run_cnt <= run_cnt + 1'b1;
                if (run_cnt == CW'(LOCK_WORDS - 1)) state <= ST_LOCK;
            end else begin
                run_cnt <= '0;
                off_q   <= (off_q == OFF_MAX) ? '0 : off_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_word_framer.sv
// Receive word framer: realigns deserialized words by searching a training
// stream for the word boundary. Assumes one valid word per clock.
module rx_word_framer #(
    parameter int W          = 10,
    parameter int LOCK_PAIRS = 4,
    localparam int OW        = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  rx_word,
    input  logic          retrain,
    input  logic          ovr_en,
    input  logic [OW-1:0] ovr_offset,
    output logic [W-1:0]  framed_word,
    output logic [W-1:0]  raw_word,
    output logic [OW-1:0] off_mon,
    output logic          locked
);
    logic [W-1:0] slice;
    logic         is_a;
    logic         is_b;

    rwf_window #(.W(W), .OW(OW)) u_window (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .off_sel(off_mon),
        .cur_word(raw_word), .slice(slice), .framed_word(framed_word)
    );

    rwf_matcher #(.W(W)) u_matcher (
        .slice(slice), .is_a(is_a), .is_b(is_b)
    );

    rwf_train_fsm #(.W(W), .OW(OW), .LOCK_PAIRS(LOCK_PAIRS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .is_a(is_a), .is_b(is_b),
        .retrain(retrain), .ovr_en(ovr_en), .ovr_offset(ovr_offset),
        .eff_off(off_mon), .locked(locked)
    );
endmodule

// File: rtl/rwf_checker.sv
// Property checker for the receive word framer, attached by bind.
module rwf_checker #(
    parameter int W  = 10,
    parameter int OW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  rx_word,
    input logic [W-1:0]  raw_word,
    input logic          retrain,
    input logic          ovr_en,
    input logic [OW-1:0] off_mon,
    input logic          locked
);
    localparam logic [OW-1:0] OFF_MAX = OW'(W - 1);

    a_r9_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        off_mon <= OFF_MAX);

    a_r2_raw_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> raw_word == $past(rx_word));

    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !ovr_en && !retrain |=> locked);

    a_r6_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) && !$past(ovr_en) && !$past(retrain) && !ovr_en
        |-> off_mon == $past(off_mon));

    a_r8_override_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |=> !locked);

    a_r7_retrain_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        retrain |=> !locked);

    a_r4_hunt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(locked) && !$past(ovr_en) && !$past(retrain) && !ovr_en
        |-> (off_mon == $past(off_mon)) ||
            (off_mon == (($past(off_mon) == OFF_MAX) ? '0 : $past(off_mon) + 1'b1)));
endmodule

bind rx_word_framer rwf_checker #(.W(W), .OW(OW)) u_rwf_checker (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .raw_word(raw_word),
    .retrain(retrain), .ovr_en(ovr_en), .off_mon(off_mon), .locked(locked)
);

// File: tb/test_rx_word_framer.sv
// Scoreboard bench for rx_word_framer.
module test_rx_word_framer;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 10;
    localparam int OW = 4;
    localparam logic [W-1:0] TA = 10'b0101010100;
    localparam logic [W-1:0] TB = 10'b1010101011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  rx_word = '0;
    logic          retrain = 1'b0;
    logic          ovr_en = 1'b0;
    logic [OW-1:0] ovr_offset = '0;
    logic [W-1:0]  framed_word;
    logic [W-1:0]  raw_word;
    logic [OW-1:0] off_mon;
    logic          locked;

    rx_word_framer #(.W(W), .LOCK_PAIRS(4)) i_rx_word_framer (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .retrain(retrain),
        .ovr_en(ovr_en), .ovr_offset(ovr_offset), .framed_word(framed_word),
        .raw_word(raw_word), .off_mon(off_mon), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit chk_en = 0;
    int exp_off = 0;
    int dly = 0;
    bit tog = 0;
    logic [W-1:0] prev_rx = '0;
    logic [W-1:0] tx_prev = '0;
    int       due_q[$];
    logic [W-1:0] val_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: called at a negedge, returns at the next negedge.
    task automatic send_rx(input logic [W-1:0] w);
        logic [2*W-1:0] cat;
        logic [2*W-1:0] sh;
        rx_word = w;
        if (chk_en) begin
            cat = {w, prev_rx};
            sh  = cat >> exp_off;
            due_q.push_back(cyc + 2);
            val_q.push_back(sh[W-1:0]);
        end
        prev_rx = w;
        @(posedge clk);
        @(negedge clk);
        check(raw_word == w, "R2", "raw word", raw_word, w);
    endtask

    // Delay a transmitted word by dly bits into the received stream.
    task automatic send_tx(input logic [W-1:0] t);
        logic [2*W-1:0] cat;
        logic [2*W-1:0] sh;
        cat = {t, tx_prev};
        sh  = cat >> (W - dly);
        tx_prev = t;
        send_rx(sh[W-1:0]);
    endtask

    task automatic send_train();
        send_tx(tog ? TB : TA);
        tog = ~tog;
    endtask

    task automatic drain();
        chk_en = 0;
        send_rx(W'($urandom));
        send_rx(W'($urandom));
    endtask

    // Monitor: compare framed output against the scoreboard (R1).
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] <= cyc) begin
            int d;
            logic [W-1:0] e;
            d = due_q.pop_front();
            e = val_q.pop_front();
            check(d == cyc && framed_word == e, "R1", "framed word", framed_word, e);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // Reset state (R4, R9)
        check(locked == 1'b0, "R4", "locked at reset", locked, 0);
        check(off_mon == 0, "R4", "offset at reset", off_mon, 0);
        check(raw_word == 0 && framed_word == 0, "R2", "outputs at reset", raw_word, 0);
        rst_n = 1'b1;

        // Search on a stream delayed by 3 bits (R3, R4, R5)
        dly = 3;
        n = 0;
        while (!locked && n < 60) begin send_train(); n++; end
        check(locked == 1'b1, "R3", "locked on training delay 3", locked, 1);
        check(off_mon == 3, "R4", "offset found for delay 3", off_mon, 3);

        // Locked data path with random data (R1, R6)
        exp_off = 3;
        chk_en = 1;
        for (int i = 0; i < 30; i++) send_tx(W'($urandom));
        drain();
        check(locked == 1'b1, "R6", "lock held on random data", locked, 1);
        check(off_mon == 3, "R6", "offset held on random data", off_mon, 3);

        // Forced offset 7 (R8, R9, R1)
        ovr_offset = 4'd7;
        ovr_en = 1'b1;
        exp_off = 7;
        chk_en = 1;
        send_rx(W'($urandom));
        check(locked == 1'b0, "R8", "override clears lock", locked, 0);
        check(off_mon == 7, "R9", "monitor shows forced offset", off_mon, 7);
        for (int i = 0; i < 20; i++) send_rx(W'($urandom));
        drain();

        // Forced value above range is clamped (R8)
        ovr_offset = 4'd12;
        exp_off = 9;
        #1;
        check(off_mon == 9, "R8", "forced 12 clamps to 9", off_mon, 9);
        chk_en = 1;
        for (int i = 0; i < 20; i++) send_rx(W'($urandom));
        drain();

        // Exact lock point after release at the right offset (R5, R8)
        ovr_offset = 4'd5;
        dly = 5;
        tx_prev = '0;
        for (int i = 0; i < 4; i++) send_train();
        ovr_en = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            send_train();
            if (i == 7) check(locked == 1'b0, "R5", "not locked after 7 words", locked, 0);
            if (i == 8) check(locked == 1'b1, "R5", "locked after 8 words", locked, 1);
        end
        check(off_mon == 5, "R8", "search resumed from forced offset", off_mon, 5);

        // Delay changes while locked: nothing moves (R6)
        dly = 8;
        for (int i = 0; i < 12; i++) send_train();
        check(locked == 1'b1, "R6", "lock held after delay change", locked, 1);
        check(off_mon == 5, "R6", "offset held after delay change", off_mon, 5);

        // Retrain resumes from current offset (R7)
        retrain = 1'b1;
        send_train();
        retrain = 1'b0;
        check(locked == 1'b0, "R7", "retrain clears lock", locked, 0);
        n = 0;
        while (!locked && n < 60) begin send_train(); n++; end
        check(locked == 1'b1 && off_mon == 8, "R7", "relock at offset 8", off_mon, 8);
        check(n <= 12, "R7", "words to relock from offset 5", n, 11);

        // Non-alternating training never locks (R5)
        retrain = 1'b1;
        send_tx(TA);
        retrain = 1'b0;
        for (int i = 0; i < 40; i++) send_tx(TA);
        check(locked == 1'b0, "R5", "repeated word A never locks", locked, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule